// File: doc/BRIEF.md
# SDRAM burst column address generator

This block steps through the column addresses of one read or write burst to a synchronous DRAM bank. A controller presents a start column, a burst length code and an ordering bit, then pulses the start strobe. From the next cycle the block presents one column address per clock with a valid flag. It raises a last-beat flag on the final beat of a finite burst.

Bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size. The order within the block is either sequential or interleaved. A full-page burst walks the whole column space, wrapping from the top column to zero, and runs until a stop or a new start arrives.

A stop strobe ends a burst of any length. A start strobe during a burst replaces it on the next clock, so a new column can be accepted every cycle. All outputs are registered, and reset is synchronous and active high.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, valid_o and last_o are low and col_o is zero.
- R2: When start_i is sampled high on a clock edge, the next cycle shows valid_o high and col_o equal to the sampled start column. Each following cycle advances one beat.
- R3: blen_i codes are 0 for 1 beat, 1 for 2, 2 for 4, 3 for 8 and 7 for full page. Codes 4, 5 and 6 behave as 1 beat.
- R4: In sequential order with length L, beat j has the column bits above log2(L) taken from the start column, and low bits equal to (start mod L + j) mod L.
- R5: In interleaved order (ilv_i = 1) with length L, beat j has the upper bits taken from the start column, and low bits equal to (start mod L) XOR j.
- R6: A full-page burst outputs start + j modulo 2^COL_W, wrapping from the top column to 0. It ignores ilv_i, never raises last_o and continues until stopped or restarted.
- R7: For finite lengths, last_o is high on exactly the final beat and valid_o falls the cycle after. A 1-beat burst raises valid_o and last_o together.
- R8: stop_i sampled high while valid_o is high, with no start, makes valid_o low on the next cycle without raising last_o. stop_i while idle has no effect, and col_o keeps its value.
- R9: A start during an active burst restarts the sequence from the new column on the next cycle. start_i has priority over a simultaneous stop_i.
- R10: Starts on consecutive cycles produce one new burst per clock, a column-to-column delay of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst at start_col_i |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | col_o holds a burst beat |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
The bench builds the block with COL_W = 5, so a full page is 32 columns. This makes it possible to sweep every start column against every length code and both orderings. A full-page burst can be run past its wrap point and then stopped within a few dozen cycles. Directed sequences then cover the cases the sweep does not reach:
- a mid-burst stop
- a stop while idle
- a restart that collides with a stop
- a reserved length code
- starts on back-to-back cycles

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'd0,
    BLC_2    = 3'd1,
    BLC_4    = 3'd2,
    BLC_8    = 3'd3,
    BLC_PAGE = 3'd7
  } blen_code_e;
endpackage

// File: rtl/col_len_decode.sv
module col_len_decode #(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  import sdram_col_pkg::*;

  always_comb begin
    full_o = 1'b0;
    case (code_i)
      BLC_2:    mask_o = COL_W'(3'b001);
      BLC_4:    mask_o = COL_W'(3'b011);
      BLC_8:    mask_o = COL_W'(3'b111);
      BLC_PAGE: begin
        mask_o = '1;
        full_o = 1'b1;
      end
      default:  mask_o = '0;
    endcase
  end
endmodule

// File: rtl/col_beat_ctrl.sv
module col_beat_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic             adv_o,
  output logic [COL_W-1:0] base_n_o,
  output logic [COL_W-1:0] beat_n_o,
  output logic [COL_W-1:0] mask_n_o,
  output logic             full_n_o,
  output logic             ilv_n_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             active_q, last_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             active_n, last_n;

  always_comb begin
    active_n = active_q;
    base_n_o = base_q;
    beat_n_o = beat_q;
    mask_n_o = mask_q;
    full_n_o = full_q;
    ilv_n_o  = ilv_q;
    adv_o    = 1'b0;
    if (start_i) begin
      active_n = 1'b1;
      base_n_o = start_col_i;
      beat_n_o = '0;
      mask_n_o = mask_i;
      full_n_o = full_i;
      ilv_n_o  = ilv_i;
      adv_o    = 1'b1;
    end else if (active_q) begin
      if (stop_i || last_q) begin
        active_n = 1'b0;
      end else begin
        beat_n_o = beat_q + COL_W'(1);
        adv_o    = 1'b1;
      end
    end
    last_n = active_n && !full_n_o && (beat_n_o == mask_n_o);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      last_q   <= 1'b0;
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
    end else begin
      active_q <= active_n;
      last_q   <= last_n;
      base_q   <= base_n_o;
      beat_q   <= beat_n_o;
      mask_q   <= mask_n_o;
      full_q   <= full_n_o;
      ilv_q    <= ilv_n_o;
    end
  end

  assign valid_o = active_q;
  assign last_o  = last_q;

  // R2: an undisturbed, unfinished burst steps its beat index by one
  assert_beat_step_R2: assert property (@(posedge clk) disable iff (rst)
    (active_q && !start_i && !stop_i && !last_q) |=>
      (active_q && beat_q == $past(beat_q) + COL_W'(1)));

  // R6: a full-page burst never reports a final beat
  assert_page_nolast_R6: assert property (@(posedge clk) disable iff (rst)
    (active_q && full_q) |-> !last_q);
endmodule

// File: rtl/col_addr_gen.sv
module col_addr_gen #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] low;

  always_comb begin
    if (ilv_i && !full_i) low = base_i ^ beat_i;
    else                  low = base_i + beat_i;
    col_o = (base_i & ~mask_i) | (low & mask_i);
  end
endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask, base_n, beat_n, mask_n, col_n;
  logic             dec_full, full_n, ilv_n, adv;

  col_len_decode #(.COL_W(COL_W)) u_dec (
    .code_i (blen_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  col_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mask_i      (dec_mask),
    .full_i      (dec_full),
    .ilv_i       (ilv_i),
    .adv_o       (adv),
    .base_n_o    (base_n),
    .beat_n_o    (beat_n),
    .mask_n_o    (mask_n),
    .full_n_o    (full_n),
    .ilv_n_o     (ilv_n),
    .valid_o     (valid_o),
    .last_o      (last_o)
  );

  col_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_n),
    .beat_i (beat_n),
    .mask_i (mask_n),
    .full_i (full_n),
    .ilv_i  (ilv_n),
    .col_o  (col_n)
  );

  always_ff @(posedge clk) begin
    if (rst)      col_o <= '0;
    else if (adv) col_o <= col_n;
  end

  // R2: a sampled start shows its column on the next cycle
  assert_start_col_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  // R8: a stop without start ends the burst on the next cycle, no last flag
  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (valid_o && stop_i && !start_i) |=> (!valid_o && !last_o));

  // R8: with no start, an idle block stays idle and holds its column
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start_i) |=> (!valid_o && $stable(col_o)));

  // R7: the final-beat flag only appears on a valid beat
  assert_last_valid_R7: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);
endmodule

// File: tb/sim_sdram_col_seq.sv
`timescale 1ns/1ps
module sim_sdram_col_seq;
  localparam int CW   = 5;
  localparam int NCOL = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [CW-1:0] start_col_i = '0;
  logic [2:0]    blen_i = 3'd0;
  logic          ilv_i = 1'b0;
  logic          stop_i = 1'b0;
  logic [CW-1:0] col_o;
  logic          valid_o, last_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sdram_col_seq #(.COL_W(CW)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int blen_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int code, input int ilv, input int j);
    int len, low, hi;
    if (code == 7) return (s + j) % NCOL;
    len = blen_of(code);
    low = s % len;
    hi  = s - low;
    if (ilv != 0) return hi + (low ^ j);
    return hi + ((low + j) % len);
  endfunction

  task automatic burst(input int s, input int code, input int ilv);
    int nb;
    string rq;
    nb = (code == 7) ? NCOL + 8 : blen_of(code);
    rq = (code == 7) ? "R6" : (ilv != 0 ? "R5" : "R4");
    @(negedge clk);
    start_i = 1'b1; start_col_i = CW'(s); blen_i = 3'(code); ilv_i = ilv[0];
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < nb; j++) begin
      chk("R2 valid", int'(valid_o), 1);
      chk(rq, int'(col_o), exp_col(s, code, ilv, j));
      chk("R7 last", int'(last_o), (code != 7 && j == nb - 1) ? 1 : 0);
      if (code == 7 && j == nb - 1) stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
    end
    chk("R7 end valid", int'(valid_o), 0);
    chk("R7 end last", int'(last_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 last", int'(last_o), 0);
    chk("R1 col", int'(col_o), 0);

    // R3 R4 R5 R6 R7: sweep of all start columns, length codes and orders
    for (int c = 0; c < 5; c++) begin
      for (int il = 0; il < 2; il++) begin
        for (int s = 0; s < NCOL; s++) begin
          burst(s, (c == 4) ? 7 : c, il);
        end
      end
    end

    // R3: reserved code 5 behaves as a single beat
    burst(9, 5, 0);
    burst(22, 6, 1);

    // R8: mid-burst stop on an 8-beat burst, then stop while idle
    @(negedge clk);
    start_i = 1'b1; start_col_i = 5'd13; blen_i = 3'd3; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < 3; j++) begin
      chk("R8 beat", int'(col_o), 8 + ((5 + j) % 8));
      if (j == 2) stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
    end
    chk("R8 stopped valid", int'(valid_o), 0);
    chk("R8 stopped last", int'(last_o), 0);
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    @(negedge clk);
    chk("R8 idle valid", int'(valid_o), 0);
    chk("R8 idle col", int'(col_o), 15);

    // R9: restart during a burst, colliding with a stop
    start_i = 1'b1; start_col_i = 5'd5; blen_i = 3'd3; ilv_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 first", int'(col_o), 5);
    @(negedge clk);
    chk("R9 second", int'(col_o), 6);
    start_i = 1'b1; stop_i = 1'b1; start_col_i = 5'd18; blen_i = 3'd2; ilv_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    for (int j = 0; j < 4; j++) begin
      chk("R9 valid", int'(valid_o), 1);
      chk("R9 col", int'(col_o), 16 + (2 ^ j));
      chk("R9 last", int'(last_o), (j == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9 end", int'(valid_o), 0);

    // R10: single-beat starts on consecutive cycles
    for (int c = 0; c < 8; c++) begin
      if (c > 0) begin
        chk("R10 col", int'(col_o), 3 * (c - 1) + 1);
        chk("R10 last", int'(last_o), 1);
      end
      start_i = 1'b1; start_col_i = CW'(3 * c + 1); blen_i = 3'd0; ilv_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
    chk("R10 col", int'(col_o), 22);
    chk("R10 valid", int'(valid_o), 1);
    @(negedge clk);
    chk("R10 end", int'(valid_o), 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule